// File: doc/BRIEF.md
# Character Display Host Data Port

This block is the processor-facing side of a character display controller. A host drives a one-cycle enable strobe together with a register-select line and a read/write line. From these, the block decodes one of four accesses: a status read, a data write, a data read, or an instruction write. It keeps a 5-bit address counter that points into one of two internal stores. One is a 32-entry byte-wide display store. The other is a 32-entry 5-bit glyph store.

Reads do not return the RAM word at the counter. They return an output latch that was filled earlier. Address loads, cursor shifts with the display store selected, and data reads each refill that latch. A data write does not. As a result, the first read after a write, or after no address load, returns stale contents.

A small state machine raises a busy flag for a fixed number of cycles after every accepted write, data read or instruction. It has two states, ST_IDLE and ST_BUSY. An accepted non-status access moves it from ST_IDLE to ST_BUSY. When its down-counter expires, it moves from ST_BUSY back to ST_IDLE. Non-status accesses that arrive while busy are dropped. Status reads are always served.

Top module: `chardisp_host_port`

## Requirements
- R1: After reset, busy is 0 and dout is 0x00. A status read then returns 0x00: counter 0, display store selected, increment direction.
- R2: A status read (rs=0, rw=1) updates dout on the enabling edge to {busy, 2'b00, counter[4:0]}, using the values present before that edge. It is served even while busy and does not itself start a busy period.
- R3: A data write (rs=1, rw=0) stores din into the selected store at the counter. The glyph store keeps only din[4:0], and bits 7..5 of any word read back from it are 0.
- R4: Every accepted data write or data read moves the counter by exactly one, up when the direction is increment and down otherwise. The counter wraps modulo 32 in both directions.
- R5: A data read (rs=1, rw=1) places the output latch on dout. It then refills the latch from the selected store at the counter's new value.
- R6: Instruction 1xxx_xxxx selects the display store, and 01xx_xxxx selects the glyph store. Both load the counter from bits 4..0 and refill the output latch from the newly addressed word.
- R7: A data write does not refill the output latch, so a read that follows a write returns the latch contents from before that write.
- R8: Instruction 0001_0Rxx moves the counter by one (R=1 up, R=0 down). It refills the output latch only when the display store is selected.
- R9: Instruction 0000_01Ix sets the counter direction, where I=1 means increment.
- R10: Each accepted data write, data read or instruction holds busy high for exactly BUSY_CYCLES clock cycles (default 4). Data and instruction accesses issued while busy change neither the counter, the stores nor dout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | One-cycle access strobe |
| rs | input | 1 | Register select: 0 instruction/status, 1 data |
| rw | input | 1 | 1 read, 0 write |
| din | input | 8 | Write data or instruction byte |
| dout | output | 8 | Status word or data read result |
| busy | output | 1 | Internal operation in progress |

## Verification
Two things can land in the same cycle: a status read, which is always served, and a running busy period. The bench provokes this by issuing a status read on the first cycle after a data write. It judges the result by checking that bit 7 of the returned word is set and that the counter field already shows the stepped address. The bench then issues a data write while busy is still high. After the busy period ends, a status read must show the counter unmoved. An address load followed by a read must show the target word unwritten.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;
    typedef enum logic [2:0] {
        OP_NONE,
        OP_STATUS,
        OP_WDATA,
        OP_RDATA,
        OP_INSTR
    } op_e;

    typedef enum logic {
        SEL_DD,
        SEL_CG
    } sel_e;

    typedef enum logic {
        ST_IDLE,
        ST_BUSY
    } bstate_e;
endpackage

// File: rtl/chardisp_decode.sv
module chardisp_decode
    import chardisp_pkg::*;
(
    input  logic en,
    input  logic rs,
    input  logic rw,
    input  logic busy,
    output op_e  op
);
    always_comb begin
        op = OP_NONE;
        if (en) begin
            unique case ({rs, rw})
                2'b01:   op = OP_STATUS;
                2'b10:   op = busy ? OP_NONE : OP_WDATA;
                2'b11:   op = busy ? OP_NONE : OP_RDATA;
                default: op = busy ? OP_NONE : OP_INSTR;
            endcase
        end
    end
endmodule

// File: rtl/chardisp_addr_ctr.sv
module chardisp_addr_ctr
    import chardisp_pkg::*;
#(
    parameter int AC_W   = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  op_e               op,
    input  logic [DATA_W-1:0] din,
    output logic [AC_W-1:0]   ac_q,
    output logic [AC_W-1:0]   ac_d,
    output sel_e              sel_q,
    output sel_e              sel_d,
    output logic              reload
);
    logic dir_q, dir_d;
    logic [AC_W-1:0] ac_step;

    assign ac_step = dir_q ? ac_q + AC_W'(1) : ac_q - AC_W'(1);

    always_comb begin
        ac_d   = ac_q;
        sel_d  = sel_q;
        dir_d  = dir_q;
        reload = 1'b0;
        unique case (op)
            OP_WDATA: ac_d = ac_step;
            OP_RDATA: begin
                ac_d   = ac_step;
                reload = 1'b1;
            end
            OP_INSTR: begin
                if (din[7]) begin
                    sel_d  = SEL_DD;
                    ac_d   = din[AC_W-1:0];
                    reload = 1'b1;
                end else if (din[6]) begin
                    sel_d  = SEL_CG;
                    ac_d   = din[AC_W-1:0];
                    reload = 1'b1;
                end else if (din[5:3] == 3'b010) begin
                    ac_d   = din[2] ? ac_q + AC_W'(1) : ac_q - AC_W'(1);
                    reload = (sel_q == SEL_DD);
                end else if (din[5:2] == 4'b0001) begin
                    dir_d = din[1];
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ac_q  <= '0;
            sel_q <= SEL_DD;
            dir_q <= 1'b1;
        end else begin
            ac_q  <= ac_d;
            sel_q <= sel_d;
            dir_q <= dir_d;
        end
    end

    AST_AC_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WDATA && dir_q) |=> ac_q == $past(ac_q) + AC_W'(1)); // R4
    AST_AC_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WDATA && !dir_q) |=> ac_q == $past(ac_q) - AC_W'(1)); // R4
endmodule

// File: rtl/chardisp_store.sv
module chardisp_store
    import chardisp_pkg::*;
#(
    parameter int AC_W   = 5,
    parameter int DATA_W = 8,
    parameter int CG_W   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  sel_e              wsel,
    input  logic [AC_W-1:0]   waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              reload,
    input  sel_e              rsel,
    input  logic [AC_W-1:0]   raddr,
    output logic [DATA_W-1:0] odr
);
    localparam int DEPTH = 1 << AC_W;

    logic [DATA_W-1:0] dd_mem [DEPTH];
    logic [CG_W-1:0]   cg_mem [DEPTH];
    logic [DATA_W-1:0] rd_word;

    assign rd_word = (rsel == SEL_DD) ? dd_mem[raddr] : DATA_W'(cg_mem[raddr]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                dd_mem[i] <= '0;
                cg_mem[i] <= '0;
            end
        end else if (we) begin
            if (wsel == SEL_DD) dd_mem[waddr] <= wdata;
            else                cg_mem[waddr] <= wdata[CG_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      odr <= '0;
        else if (reload) odr <= rd_word;
    end

    AST_CG_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reload && rsel == SEL_CG) |=> odr[DATA_W-1:CG_W] == '0); // R3
    AST_WRITE_NO_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (we && !reload) |=> $stable(odr)); // R7
endmodule

// File: rtl/chardisp_busy_fsm.sv
module chardisp_busy_fsm
    import chardisp_pkg::*;
#(
    parameter int BUSY_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = (BUSY_CYCLES > 1) ? $clog2(BUSY_CYCLES) : 1;

    bstate_e state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: if (start) begin
                state_d = ST_BUSY;
                cnt_d   = CNT_W'(BUSY_CYCLES - 1);
            end
            ST_BUSY: if (cnt_q == '0) state_d = ST_IDLE;
                     else             cnt_d   = cnt_q - CNT_W'(1);
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb busy = (state_q == ST_BUSY);

    AST_BUSY_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy); // R10
    AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !start); // R10
endmodule

// File: rtl/chardisp_host_port.sv
module chardisp_host_port
    import chardisp_pkg::*;
#(
    parameter int AC_W        = 5,
    parameter int DATA_W      = 8,
    parameter int CG_W        = 5,
    parameter int BUSY_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              rs,
    input  logic              rw,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] dout,
    output logic              busy
);
    op_e               op;
    logic [AC_W-1:0]   ac_q, ac_d;
    sel_e              sel_q, sel_d;
    logic              reload;
    logic [DATA_W-1:0] odr;
    logic [DATA_W-1:0] status_word;
    logic              start;

    chardisp_decode u_decode (
        .en(en), .rs(rs), .rw(rw), .busy(busy), .op(op)
    );

    chardisp_addr_ctr #(.AC_W(AC_W), .DATA_W(DATA_W)) u_addr (
        .clk(clk), .rst_n(rst_n), .op(op), .din(din),
        .ac_q(ac_q), .ac_d(ac_d), .sel_q(sel_q), .sel_d(sel_d), .reload(reload)
    );

    chardisp_store #(.AC_W(AC_W), .DATA_W(DATA_W), .CG_W(CG_W)) u_store (
        .clk(clk), .rst_n(rst_n),
        .we(op == OP_WDATA), .wsel(sel_q), .waddr(ac_q), .wdata(din),
        .reload(reload), .rsel(sel_d), .raddr(ac_d), .odr(odr)
    );

    assign start = (op == OP_WDATA) || (op == OP_RDATA) || (op == OP_INSTR);

    chardisp_busy_fsm #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(start), .busy(busy)
    );

    always_comb begin
        status_word             = '0;
        status_word[DATA_W-1]   = busy;
        status_word[AC_W-1:0]   = ac_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                dout <= '0;
        else if (op == OP_STATUS)  dout <= status_word;
        else if (op == OP_RDATA)   dout <= odr;
    end

    AST_IGNORE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && en && !(!rs && rw)) |=> ($stable(ac_q) && $stable(dout))); // R10
    AST_STATUS_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && en && !rs && rw) |=> !busy); // R2
endmodule

// File: tb/chardisp_host_port_bench.sv
module chardisp_host_port_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       rs = 1'b0;
    logic       rw = 1'b0;
    logic [7:0] din = '0;
    logic [7:0] dout;
    logic       busy;
    int nchk = 0;
    int nerr = 0;

    always #10 clk = ~clk;

    chardisp_host_port u_chardisp_host_port (
        .clk(clk), .rst_n(rst_n), .en(en), .rs(rs), .rw(rw),
        .din(din), .dout(dout), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h", tag, act, exp);
        end
    endtask

    task automatic access(input logic r, input logic w, input logic [7:0] d);
        @(negedge clk);
        en = 1'b1; rs = r; rw = w; din = d;
        @(negedge clk);
        en = 1'b0;
    endtask

    task automatic wait_idle;
        while (busy) @(negedge clk);
    endtask

    task automatic cmd(input logic r, input logic w, input logic [7:0] d);
        access(r, w, d);
        wait_idle();
    endtask

    task automatic status(output logic [7:0] s);
        access(1'b0, 1'b1, 8'h00);
        s = dout;
    endtask

    task automatic rd(output logic [7:0] v);
        access(1'b1, 1'b1, 8'h00);
        v = dout;
        wait_idle();
    endtask

    task automatic t_reset;
        logic [7:0] s;
        chk(dout == 8'h00, "R1 dout after reset", dout, 8'h00);
        chk(busy == 1'b0, "R1 busy after reset", {7'b0, busy}, 8'h00);
        status(s);
        chk(s == 8'h00, "R1 status after reset", s, 8'h00);
    endtask

    task automatic t_write_read;
        logic [7:0] v;
        cmd(1'b0, 1'b0, 8'h83);
        status(v);
        chk(v == 8'h03, "R6 counter load", v, 8'h03);
        cmd(1'b1, 1'b0, 8'hA5);
        status(v);
        chk(v == 8'h04, "R4 step after write", v, 8'h04);
        cmd(1'b1, 1'b0, 8'h5A);
        cmd(1'b0, 1'b0, 8'h83);
        rd(v);
        chk(v == 8'hA5, "R6 read after address load", v, 8'hA5);
        rd(v);
        chk(v == 8'h5A, "R5 latch refilled by read", v, 8'h5A);
        status(v);
        chk(v == 8'h05, "R4 step after reads", v, 8'h05);
    endtask

    task automatic t_stale;
        logic [7:0] v;
        cmd(1'b0, 1'b0, 8'h8A);
        cmd(1'b1, 1'b0, 8'h77);
        rd(v);
        chk(v == 8'h00, "R7 stale read after write", v, 8'h00);
        cmd(1'b0, 1'b0, 8'h8A);
        rd(v);
        chk(v == 8'h77, "R7 data after reload", v, 8'h77);
    endtask

    task automatic t_glyph;
        logic [7:0] v;
        cmd(1'b0, 1'b0, 8'h42);
        cmd(1'b1, 1'b0, 8'hFF);
        cmd(1'b0, 1'b0, 8'h42);
        rd(v);
        chk(v == 8'h1F, "R3 glyph store keeps 5 bits", v, 8'h1F);
        status(v);
        chk(v == 8'h03, "R4 glyph read step", v, 8'h03);
    endtask

    task automatic t_dir_wrap;
        logic [7:0] v;
        cmd(1'b0, 1'b0, 8'h04);
        cmd(1'b0, 1'b0, 8'h80);
        cmd(1'b1, 1'b0, 8'h11);
        status(v);
        chk(v == 8'h1F, "R9 R4 decrement wraps below 0", v, 8'h1F);
        cmd(1'b0, 1'b0, 8'h06);
        cmd(1'b0, 1'b0, 8'h9F);
        cmd(1'b1, 1'b0, 8'h22);
        status(v);
        chk(v == 8'h00, "R9 R4 increment wraps above 31", v, 8'h00);
        cmd(1'b0, 1'b0, 8'h9F);
        rd(v);
        chk(v == 8'h22, "R4 word at top address", v, 8'h22);
    endtask

    task automatic t_shift;
        logic [7:0] v;
        cmd(1'b0, 1'b0, 8'h82);
        cmd(1'b0, 1'b0, 8'h14);
        rd(v);
        chk(v == 8'hA5, "R8 right shift reloads latch", v, 8'hA5);
        cmd(1'b0, 1'b0, 8'h10);
        status(v);
        chk(v == 8'h03, "R8 left shift moves counter", v, 8'h03);
        rd(v);
        chk(v == 8'hA5, "R8 left shift reloads latch", v, 8'hA5);
        cmd(1'b0, 1'b0, 8'h42);
        cmd(1'b0, 1'b0, 8'h14);
        rd(v);
        chk(v == 8'h1F, "R8 no reload with glyph store", v, 8'h1F);
        cmd(1'b0, 1'b0, 8'h80);
    endtask

    task automatic t_busy;
        logic [7:0] v;
        int n;
        cmd(1'b0, 1'b0, 8'h94);
        access(1'b1, 1'b0, 8'h31);
        n = 0;
        while (busy) begin
            n++;
            @(negedge clk);
        end
        chk(n == 4, "R10 busy length", 8'(n), 8'd4);
        access(1'b1, 1'b0, 8'h32);
        status(v);
        chk(v == 8'h96, "R2 status while busy", v, 8'h96);
        access(1'b1, 1'b0, 8'hEE);
        wait_idle();
        status(v);
        chk(v == 8'h16, "R10 counter kept while busy", v, 8'h16);
        chk(busy == 1'b0, "R2 status starts no busy", {7'b0, busy}, 8'h00);
        cmd(1'b0, 1'b0, 8'h96);
        rd(v);
        chk(v == 8'h00, "R10 ignored write left store", v, 8'h00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nerr++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_stale();
        t_glyph();
        t_dir_wrap();
        t_shift();
        t_busy();
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule